// File: doc/BRIEF.md
# Register File with Undo Log

This block holds a register file that is written speculatively: a result goes into its register as soon as it is produced, even when older instructions have not yet finished. So that the written state can be taken back, every accepted write first records what it overwrites. The record holds the register number, the value it held before, and the PC of the instruction that wrote it. The records sit in a circular log. When the oldest outstanding instruction commits, its record is dropped from the log, because that write can no longer be undone.

When a fault is signalled, for example by an older load that faults after a younger instruction has already written back, the block stops accepting writes. It then takes records from the newest end of the log, one per cycle, and writes each saved value back into its register. When the log is empty, the register file again holds only committed state. The block then pulses a one-cycle restart indication that carries the faulting instruction's PC. Register 0 always reads zero, and writes to it are dropped without a record.

Top module: `regfile_undo_log`

## Requirements
- R1: After reset, every register reads zero, `busy` and `restart_valid` are low and `wr_ready` is high.
- R2: A write with `wr_en` high, `wr_ready` high and a nonzero `wr_idx` shows on `rd_data` from the next cycle.
- R3: Each accepted write logs the previous register value, the register number and `wr_pc`. In every rollback cycle that undoes an entry, `undo_pc` shows that entry's PC.
- R4: A write to register 0 changes nothing and adds no log entry.
- R5: The log holds 16 entries. With 16 uncommitted entries, `wr_ready` is low and a write attempt is refused, leaving its register unchanged.
- R6: A `commit` pulse while not busy drops the oldest entry. That write survives any later rollback, and a full log can accept a write again.
- R7: On `except_req` while not busy, `busy` rises on the next cycle and entries are undone newest first, one per cycle. `busy` stays high for N+1 cycles when N entries are outstanding. Several writes to one register therefore restore its oldest logged value.
- R8: While `busy` is high, `wr_ready` is low and writes have no effect.
- R9: In the cycle `busy` falls, `restart_valid` is high for exactly one cycle and `restart_pc` holds the PC given with the exception.
- R10: When `commit` and `except_req` arrive in the same cycle, the commit is applied first and the committed write is not undone.
- R11: `commit` and `except_req` are ignored while `busy` is high.
- R12: `commit` with an empty log has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Destination register |
| wr_data | input | DATA_W | New value |
| wr_pc | input | PC_W | PC of the writing instruction |
| wr_ready | output | 1 | Write can be accepted this cycle |
| commit | input | 1 | Oldest outstanding instruction commits |
| except_req | input | 1 | Start a rollback |
| except_pc | input | PC_W | PC of the faulting instruction |
| busy | output | 1 | Rollback in progress |
| undo_pc | output | PC_W | PC of the entry being undone |
| restart_valid | output | 1 | One-cycle pulse when the rollback ends |
| restart_pc | output | PC_W | PC to restart from |
| rd_idx | input | IDX_W | Read register |
| rd_data | output | DATA_W | Read value, combinational |

## Verification
The commit that drops the oldest log entry and the exception that starts the rollback can fall in the same cycle. The bench provokes this by raising both on one edge with two entries outstanding. It passes only if the rollback lasts two cycles, the older write keeps its new value and the younger one is restored. A second overlap puts a commit, a write and a fresh exception inside the first rollback cycle. The bench judges it by the rollback length, by the restart PC and by the untouched target register.

// File: rtl/undo_pkg.sv
// Shared definitions for the register file with undo log.
// Assumes: nothing beyond standard SystemVerilog.
package undo_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_UNDO = 1'b1
    } undo_state_e;
endpackage

// File: rtl/undo_arch_regs.sv
// Register array with one write port and two combinational read ports.
// Entry 0 is a constant zero. Assumes the caller never writes index 0.
module undo_arch_regs #(
    parameter int NREGS = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [NREGS-1:0][DW-1:0] flat;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign flat[g] = '0;
        end else begin : g_flop
            logic [DW-1:0] q;
            // Hold one register, loading it when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && waddr == IW'(g))
                    q <= wdata;
            end
            assign flat[g] = q;
        end
    end

    // Read ports index the flattened array.
    always_comb begin
        rdata_a = flat[raddr_a];
        rdata_b = flat[raddr_b];
    end

    // R4: upstream filtering keeps writes off the zero register.
    a_r4_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr != '0);
endmodule

// File: rtl/undo_history_fifo.sv
// Circular log of undo records. Supports a push at the newest end, a pop at
// the oldest end (commit) and a pop at the newest end (rollback).
// Assumes the two pops are never requested together and that a push never
// meets a newest-end pop.
module undo_history_fifo #(
    parameter int DEPTH = 16,
    parameter int EW    = 96,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop_old,
    input  logic          pop_new,
    output logic [EW-1:0] newest,
    output logic          empty,
    output logic          full
);
    logic [EW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q, tail_prev;
    logic [CNT_W-1:0] count_q;

    // Slot behind the tail holds the newest record.
    always_comb begin
        tail_prev = (tail_q == '0) ? PTR_W'(DEPTH - 1) : tail_q - 1'b1;
        newest    = mem[tail_prev];
        empty     = (count_q == '0);
        full      = (count_q == CNT_W'(DEPTH));
    end

    // Store pushed records; storage needs no reset.
    always_ff @(posedge clk) begin
        if (push)
            mem[tail_q] <= push_data;
    end

    // Move the pointers and occupancy for each operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push)
                tail_q <= (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
            else if (pop_new)
                tail_q <= tail_prev;
            if (pop_old)
                head_q <= (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
            if (push && !pop_old)
                count_q <= count_q + 1'b1;
            else if (!push && (pop_old || pop_new))
                count_q <= count_q - 1'b1;
        end
    end

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old || pop_new) |-> !empty);
    a_r11_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_old && pop_new));
endmodule

// File: rtl/undo_rollback_ctrl.sv
// Rollback sequencer: on an exception it undoes one record per cycle until
// the log is empty, then pulses the restart indication with the fault PC.
// Assumes log_empty reflects the log state in the current cycle.
module undo_rollback_ctrl
    import undo_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          except_req,
    input  logic [PW-1:0] except_pc,
    input  logic          log_empty,
    output logic          busy,
    output logic          undo_pop,
    output logic          restart_valid,
    output logic [PW-1:0] restart_pc
);
    undo_state_e   state_q;
    logic          restart_q;
    logic [PW-1:0] pc_q;

    // Step between running and undoing; latch the fault PC on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            restart_q <= 1'b0;
            pc_q      <= '0;
        end else begin
            restart_q <= 1'b0;
            case (state_q)
                ST_RUN: if (except_req) begin
                    state_q <= ST_UNDO;
                    pc_q    <= except_pc;
                end
                ST_UNDO: if (log_empty) begin
                    state_q   <= ST_RUN;
                    restart_q <= 1'b1;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Outputs follow directly from the state.
    always_comb begin
        busy          = (state_q == ST_UNDO);
        undo_pop      = busy && !log_empty;
        restart_valid = restart_q;
        restart_pc    = pc_q;
    end

    a_r7_drain_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && log_empty) |=> !busy);
    a_r9_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> (!busy && $past(busy)));
    a_r11_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(restart_pc));
endmodule

// File: rtl/regfile_undo_log.sv
// Top: speculative register file with an undo log. Writes land at once and
// log the overwritten value; commits retire the oldest record; an exception
// rolls the file back newest-first. Assumes one write per cycle.
module regfile_undo_log #(
    parameter int NUM_REGS  = 32,
    parameter int DATA_W    = 32,
    parameter int PC_W      = 32,
    parameter int LOG_DEPTH = 16,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PC_W-1:0]   wr_pc,
    output logic              wr_ready,
    input  logic              commit,
    input  logic              except_req,
    input  logic [PC_W-1:0]   except_pc,
    output logic              busy,
    output logic [PC_W-1:0]   undo_pc,
    output logic              restart_valid,
    output logic [PC_W-1:0]   restart_pc,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRY_W = PC_W + IDX_W + DATA_W;

    logic               log_full, log_empty, undo_pop, wr_fire, commit_pop;
    logic [ENTRY_W-1:0] log_newest;
    logic [DATA_W-1:0]  prev_val, undo_val, rf_wdata;
    logic [IDX_W-1:0]   undo_idx, rf_waddr;

    // Accept, commit and write-port selection.
    always_comb begin
        wr_ready   = !log_full && !busy;
        wr_fire    = wr_en && wr_ready && (wr_idx != '0);
        commit_pop = commit && !log_empty && !busy;
        undo_val   = log_newest[DATA_W-1:0];
        undo_idx   = log_newest[DATA_W +: IDX_W];
        undo_pc    = log_newest[DATA_W + IDX_W +: PC_W];
        rf_waddr   = busy ? undo_idx : wr_idx;
        rf_wdata   = busy ? undo_val : wr_data;
    end

    undo_arch_regs #(.NREGS(NUM_REGS), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_fire || undo_pop),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (wr_idx),
        .rdata_a (prev_val),
        .raddr_b (rd_idx),
        .rdata_b (rd_data)
    );

    undo_history_fifo #(.DEPTH(LOG_DEPTH), .EW(ENTRY_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_fire),
        .push_data ({wr_pc, wr_idx, prev_val}),
        .pop_old   (commit_pop),
        .pop_new   (undo_pop),
        .newest    (log_newest),
        .empty     (log_empty),
        .full      (log_full)
    );

    undo_rollback_ctrl #(.PW(PC_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .except_req    (except_req),
        .except_pc     (except_pc),
        .log_empty     (log_empty),
        .busy          (busy),
        .undo_pop      (undo_pop),
        .restart_valid (restart_valid),
        .restart_pc    (restart_pc)
    );

    a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_fire);
    a_r11_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit_pop);
    a_r7_undo_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        undo_pop |-> busy);
endmodule

// File: tb/test_regfile_undo_log.sv
`timescale 1ns/1ps
module test_regfile_undo_log;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, commit = 1'b0, except_req = 1'b0;
    logic [4:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0, wr_pc = '0, except_pc = '0;
    logic        wr_ready, busy, restart_valid;
    logic [31:0] undo_pc, restart_pc, rd_data;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    regfile_undo_log i_regfile_undo_log (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_pc(wr_pc), .wr_ready(wr_ready),
        .commit(commit), .except_req(except_req), .except_pc(except_pc),
        .busy(busy), .undo_pc(undo_pc), .restart_valid(restart_valid),
        .restart_pc(restart_pc), .rd_idx(rd_idx), .rd_data(rd_data));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] val);
        rd_idx = idx;
        #0.5;
        val = rd_data;
    endtask

    task automatic chk_reg(string req, logic [4:0] idx, logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        chk(req, v, exp);
    endtask

    task automatic wr(logic [4:0] idx, logic [31:0] d, logic [31:0] pc);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_pc = pc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmt();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    // Raise an exception (optionally with a commit in the same cycle) and
    // count busy cycles. disturb: inject commit, write and exception while busy.
    task automatic exc(logic [31:0] pc, bit with_commit, bit disturb,
                       output int n, output logic [31:0] upc0,
                       output logic [31:0] upc1);
        @(negedge clk);
        except_req = 1'b1; except_pc = pc; commit = with_commit;
        @(negedge clk);
        except_req = 1'b0; commit = 1'b0;
        n = 0; upc0 = '0; upc1 = '0;
        while (busy && n < 100) begin
            if (n == 0) upc0 = undo_pc;
            if (n == 1) upc1 = undo_pc;
            if (disturb && n == 0) begin
                chk("R8 wr_ready low while busy", {31'b0, wr_ready}, 32'd0);
                commit = 1'b1; except_req = 1'b1; except_pc = 32'h77;
                wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'hBEEF;
            end else begin
                commit = 1'b0; except_req = 1'b0; wr_en = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        chk("R9 restart_valid at busy fall", {31'b0, restart_valid}, 32'd1);
        chk("R9 restart_pc", restart_pc, pc);
        @(negedge clk);
        chk("R9 restart_valid one cycle", {31'b0, restart_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 wr_ready", {31'b0, wr_ready}, 32'd1);
        chk("R1 restart_valid", {31'b0, restart_valid}, 32'd0);
        for (int i = 0; i < 32; i += 7) chk_reg("R1 reg zero", 5'(i), 32'd0);
    endtask

    task automatic t_write_zero();
        int n; logic [31:0] a, b;
        wr(5'd0, 32'h1234, 32'h4);
        chk_reg("R4 r0 reads zero", 5'd0, 32'd0);
        wr(5'd0, 32'h1, 32'h8); wr(5'd0, 32'h2, 32'hC);
        wr(5'd5, 32'hA5, 32'h10);
        chk_reg("R2 r5 written", 5'd5, 32'hA5);
        exc(32'h10, 0, 0, n, a, b);
        chk("R4 r0 not logged (busy length)", n, 2);
        chk("R3 undo_pc of r5 entry", a, 32'h10);
        chk_reg("R3 r5 restored", 5'd5, 32'd0);
    endtask

    task automatic t_empty_commit();
        int n; logic [31:0] a, b;
        cmt(); cmt();
        wr(5'd7, 32'h77, 32'h20); wr(5'd6, 32'h66, 32'h24);
        exc(32'h20, 0, 0, n, a, b);
        chk("R12 empty commit harmless (busy length)", n, 3);
        chk_reg("R12 r7 restored", 5'd7, 32'd0);
        chk_reg("R12 r6 restored", 5'd6, 32'd0);
    endtask

    task automatic t_order();
        int n; logic [31:0] a, b;
        wr(5'd3, 32'h11, 32'h30); cmt();
        wr(5'd3, 32'h22, 32'h34); wr(5'd3, 32'h33, 32'h38);
        exc(32'h34, 0, 0, n, a, b);
        chk("R7 busy length", n, 3);
        chk("R3 first undo_pc newest", a, 32'h38);
        chk("R3 second undo_pc", b, 32'h34);
        chk_reg("R7 newest-first restores committed", 5'd3, 32'h11);
    endtask

    task automatic t_full();
        int n; logic [31:0] a, b;
        for (int i = 1; i <= 16; i++) wr(5'(i), 32'h100 + i, 32'h40 + 4 * i);
        @(negedge clk);
        chk("R5 wr_ready low when full", {31'b0, wr_ready}, 32'd0);
        wr(5'd17, 32'hDEAD, 32'h90);
        chk_reg("R5 refused write", 5'd17, 32'd0);
        cmt();
        chk("R6 wr_ready after commit", {31'b0, wr_ready}, 32'd1);
        exc(32'h99, 0, 1, n, a, b);
        chk("R11 commit ignored while busy (busy length)", n, 16);
        chk_reg("R6 committed r1 kept", 5'd1, 32'h101);
        chk_reg("R7 r2 restored", 5'd2, 32'd0);
        chk_reg("R7 r16 restored", 5'd16, 32'd0);
        chk_reg("R8 write while busy dropped", 5'd20, 32'd0);
        for (int i = 1; i <= 16; i++) if (i == 1) cmt();
    endtask

    task automatic t_same_cycle();
        int n; logic [31:0] a, b;
        wr(5'd8, 32'h1, 32'h50); wr(5'd9, 32'h2, 32'h54);
        exc(32'h54, 1, 0, n, a, b);
        chk("R10 busy length after commit", n, 2);
        chk_reg("R10 committed r8 kept", 5'd8, 32'h1);
        chk_reg("R10 r9 restored", 5'd9, 32'd0);
    endtask

    initial begin
        #5000000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_zero();
        t_empty_commit();
        t_order();
        t_full();
        t_same_cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule